// File: doc/BRIEF.md
# UART Line Status Tracker

This block holds the line-status flags of a UART whose receiver fills a 16-entry receive FIFO and whose transmitter has a holding register that feeds a shift register. Every received character enters the FIFO with three error bits: parity, framing and break. The block stores the characters, reports the oldest one, and builds an 8-bit status word from the FIFO state, from the error bits of the character at the head, and from the empty indications of the transmit holding and shift registers.

Software reads the status word by pulsing a read strobe. The word shows the flag values of the cycle in which the strobe is high. The overrun, parity, framing and break flags clear after the read. The aggregate FIFO-error flag clears only when no errored character is left queued. A flag whose setting event falls in the same cycle as a read keeps its new value, so no event is lost. The serial engines and the interrupt logic are outside this block.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word is 8'h60, the FIFO is empty, and only the holding-empty bit (bit 5) and the transmitter-empty bit (bit 6) are 1.
- R2: Bit 0 is 1 whenever the FIFO holds at least one character. `rx_data` shows the oldest character, and characters leave in the order they were pushed.
- R3: `rx_push_err` uses bit 0 for parity, bit 1 for framing and bit 2 for break. In the cycle after a character reaches the FIFO head, status bits 2, 3 and 4 are set for each error bit that character carries.
- R4: A status read clears bits 1 to 4 in the following cycle. A flag whose set event occurs in the same cycle as the read stays 1.
- R5: A push while the FIFO holds 16 characters, with no pop in the same cycle, discards the character and sets bit 1 (overrun) in the next cycle.
- R6: Bit 5 is 0 in the cycle after a holding-register write. It returns to 1 in the cycle after `thr_empty` is seen high with no write.
- R7: Bit 6 is 1 only in the cycle after a cycle in which `thr_empty` and `tsr_empty` are both high and no write occurred. It implies bit 5.
- R8: Bit 7 is 1 in the cycle after a character with any error bit set is accepted into the FIFO.
- R9: A status read leaves bit 7 at 1 if errored characters are still queued after that cycle, and clears it otherwise.
- R10: Popping characters does not clear bit 7. Only a read can clear it.
- R11: A pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_push | input | 1 | Pushes a received character |
| rx_push_data | input | 8 | Character to push |
| rx_push_err | input | 3 | Error bits of the pushed character ([0] parity, [1] framing, [2] break) |
| rx_pop | input | 1 | Removes the head character |
| rx_data | output | 8 | Character at the FIFO head |
| thr_write | input | 1 | Write strobe to the transmit holding register |
| thr_empty | input | 1 | Holding register is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| status_rd | input | 1 | Status-word read strobe |
| status | output | 8 | Line status word |

## Verification
Clean characters are pushed and popped to confirm FIFO order and the ready bit, and a pop on an empty FIFO is tested to confirm it has no effect. Errored characters are placed behind a clean head and then directly at the head, which shows that the head flags follow the head and not the push. Reads are issued with an errored character still queued, with the queue drained, and in the same cycle as a new errored head arrives. This separates the conditional clear of the aggregate bit and the set-wins rule from a plain clear. A full FIFO is overfilled to check the overrun flag and that the extra character is dropped. The holding and shift empty inputs are stepped on their own to show when each transmit bit changes.

// File: rtl/uls_pkg.sv
// Package: shared constants for the UART line status tracker.
// Assumes the error vector carries parity, framing and break in that bit order.
package uls_pkg;
    localparam int ERR_W     = 3;
    localparam int ERR_PAR   = 0;
    localparam int ERR_FRM   = 1;
    localparam int ERR_BRK   = 2;
    localparam int ST_READY  = 0;
    localparam int ST_OVRUN  = 1;
    localparam int ST_HEAD0  = 2;   // first of the ERR_W head error bits
    localparam int ST_THRE   = 5;
    localparam int ST_TEMT   = 6;
    localparam int ST_FIFOER = 7;
endpackage

// File: rtl/uls_rx_fifo.sv
// Module: receive FIFO of data and error bits, with a count of errored entries.
// Assumes: pushes into a full FIFO are dropped unless a pop frees a slot in the
// same cycle; pops on an empty FIFO are ignored. It also reports when a new
// character becomes the head, and that character's error bits.
module uls_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ERR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ERR_W-1:0]  push_err,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              not_empty,
    output logic              full,
    output logic              arrive,
    output logic [ERR_W-1:0]  arrive_err,
    output logic              err_push,
    output logic              err_left
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT_W = DATA_W + ERR_W;

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_nxt_ptr;
    logic [CNT_W-1:0] count, err_cnt, err_cnt_nxt;
    logic             push_ok, pop_ok, head_has_err;
    logic [ERR_W-1:0] head_err, next_err;

    // Pointer advance with wrap for any depth
    function automatic logic [PTR_W-1:0] inc_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept and remove decisions for this cycle
    always_comb begin
        pop_ok     = pop && (count != '0);
        push_ok    = push && ((count != CNT_W'(DEPTH)) || pop_ok);
        full       = (count == CNT_W'(DEPTH));
        not_empty  = (count != '0);
        rd_nxt_ptr = inc_ptr(rd_ptr);
        head_data  = mem[rd_ptr][DATA_W-1:0];
        head_err   = mem[rd_ptr][ENT_W-1:DATA_W];
        next_err   = mem[rd_nxt_ptr][ENT_W-1:DATA_W];
    end

    // New-head detection and the errors the new head carries
    always_comb begin
        arrive     = 1'b0;
        arrive_err = '0;
        if (push_ok && ((count == '0) || (count == CNT_W'(1) && pop_ok))) begin
            arrive     = 1'b1;
            arrive_err = push_err;
        end else if (pop_ok && (count > CNT_W'(1))) begin
            arrive     = 1'b1;
            arrive_err = next_err;
        end
    end

    // Errored-entry count after this cycle's push and pop
    always_comb begin
        head_has_err = |head_err;
        err_push     = push_ok && (|push_err);
        err_cnt_nxt  = err_cnt + {{(CNT_W-1){1'b0}}, err_push}
                               - {{(CNT_W-1){1'b0}}, pop_ok && head_has_err};
        err_left     = (err_cnt_nxt != '0);
    end

    // Storage write; entries carry no reset
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= {push_err, push_data};
        end
    end

    // Pointers and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (push_ok) wr_ptr <= inc_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= rd_nxt_ptr;
            count   <= count + {{(CNT_W-1){1'b0}}, push_ok}
                             - {{(CNT_W-1){1'b0}}, pop_ok};
            err_cnt <= err_cnt_nxt;
        end
    end
endmodule

// File: rtl/uls_sticky.sv
// Module: one sticky status flag.
// Assumes set has priority over clear, so an event that coincides with a read is kept.
module uls_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, set or clear the flag
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set | (q & ~clr);
    end
endmodule

// File: rtl/uls_tx_status.sv
// Module: transmit-side empty flags.
// Assumes the holding register lowers thr_empty by the cycle after a write, and
// that tsr_empty comes from the shift register.
module uls_tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_write,
    input  logic thr_empty,
    input  logic tsr_empty,
    output logic thre,
    output logic temt
);
    // Holding-empty and transmitter-empty tracking; a write wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre <= 1'b1;
            temt <= 1'b1;
        end else begin
            thre <= !thr_write && (thr_empty || thre);
            temt <= !thr_write && thr_empty && tsr_empty;
        end
    end
endmodule

// File: rtl/uart_line_status.sv
// Module: UART line status tracker top.
// Combines the receive FIFO, the sticky head and overrun flags, the FIFO-error
// aggregate and the transmit empty flags into one read-to-clear status word.
module uart_line_status #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic [2:0]        rx_push_err,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    input  logic              thr_write,
    input  logic              thr_empty,
    input  logic              tsr_empty,
    input  logic              status_rd,
    output logic [7:0]        status
);
    import uls_pkg::*;

    logic             fifo_ready, fifo_full, head_arrive, err_push, err_left;
    logic [ERR_W-1:0] arrive_err, head_flag;
    logic             ovr_flag, thre, temt, fifo_err_q;

    uls_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ERR_W(ERR_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data), .push_err(rx_push_err),
        .pop(rx_pop), .head_data(rx_data), .not_empty(fifo_ready),
        .full(fifo_full), .arrive(head_arrive), .arrive_err(arrive_err),
        .err_push(err_push), .err_left(err_left)
    );

    // One sticky flag per head error bit
    for (genvar i = 0; i < ERR_W; i++) begin : g_head
        uls_sticky u_flag (
            .clk(clk), .rst_n(rst_n),
            .set(head_arrive && arrive_err[i]), .clr(status_rd),
            .q(head_flag[i])
        );
    end

    uls_sticky u_ovr (
        .clk(clk), .rst_n(rst_n),
        .set(rx_push && fifo_full && !rx_pop), .clr(status_rd),
        .q(ovr_flag)
    );

    uls_tx_status u_tx (
        .clk(clk), .rst_n(rst_n), .thr_write(thr_write),
        .thr_empty(thr_empty), .tsr_empty(tsr_empty),
        .thre(thre), .temt(temt)
    );

    // Aggregate FIFO error: set on an errored push, read clears only when none remain
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_err_q <= 1'b0;
        else        fifo_err_q <= err_push || (status_rd ? err_left : fifo_err_q);
    end

    // Assemble the status word
    always_comb begin
        status                               = '0;
        status[ST_READY]                     = fifo_ready;
        status[ST_OVRUN]                     = ovr_flag;
        status[ST_HEAD0 +: ERR_W]            = head_flag;
        status[ST_THRE]                      = thre;
        status[ST_TEMT]                      = temt;
        status[ST_FIFOER]                    = fifo_err_q;
    end
endmodule

// File: rtl/uls_checker.sv
// Module: temporal checks on the line status tracker, bound to its top.
module uls_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_push,
    input logic [2:0] rx_push_err,
    input logic       rx_pop,
    input logic       thr_write,
    input logic       tsr_empty,
    input logic       status_rd,
    input logic [7:0] status,
    input logic       fifo_full,
    input logic       head_arrive
);
    a_r2_ready_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> status[0]);
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !head_arrive) |=> (status[4:2] == 3'b000));
    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && fifo_full && !rx_pop) |=> status[1]);
    a_r6_thre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        thr_write |=> !status[5]);
    a_r7_temt_implies_thre: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> status[5]);
    a_r7_temt_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !tsr_empty |=> !status[6]);
    a_r8_fifo_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && (|rx_push_err) && (!fifo_full || rx_pop)) |=> status[7]);
    a_r10_fifo_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !status_rd) |=> status[7]);
endmodule

bind uart_line_status uls_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_push_err(rx_push_err),
    .rx_pop(rx_pop), .thr_write(thr_write), .tsr_empty(tsr_empty),
    .status_rd(status_rd), .status(status), .fifo_full(fifo_full),
    .head_arrive(head_arrive)
);

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_push_data = '0;
    logic [2:0] rx_push_err = '0;
    logic [7:0] rx_data, status;
    logic       thr_write = 1'b0, thr_empty = 1'b1, tsr_empty = 1'b1, status_rd = 1'b0;
    int         checks = 0, errors = 0, cycles = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uart_line_status u_dut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_push_err(rx_push_err), .rx_pop(rx_pop), .rx_data(rx_data),
        .thr_write(thr_write), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
        .status_rd(status_rd), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock edge; inputs were set after a falling edge, results read after the next one
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0; status_rd = 1'b0; thr_write = 1'b0;
        rx_push_err = '0;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        rx_push = 1'b1; rx_push_data = d; rx_push_err = e; cyc();
    endtask

    task automatic pop();  rx_pop = 1'b1; cyc(); endtask
    task automatic rd();   status_rd = 1'b1; cyc(); endtask

    task automatic t_reset();
        chk("R1 reset word", status, 8'h60);
    endtask

    task automatic t_order();
        push(8'hA1, 3'b000); push(8'hB2, 3'b000); push(8'hC3, 3'b000);
        chk("R2 ready", {7'b0, status[0]}, 8'h01);
        chk("R2 head first", rx_data, 8'hA1);
        pop();
        chk("R2 head second", rx_data, 8'hB2);
        pop(); pop();
        chk("R2 empty", {7'b0, status[0]}, 8'h00);
        pop();
        chk("R11 pop empty keeps empty", {7'b0, status[0]}, 8'h00);
        push(8'hD4, 3'b000);
        chk("R11 head after empty pop", rx_data, 8'hD4);
        pop();
        chk("R11 single entry", {7'b0, status[0]}, 8'h00);
    endtask

    task automatic t_head_err();
        push(8'h11, 3'b000); push(8'h22, 3'b010);
        chk("R3 clean head no framing", {7'b0, status[3]}, 8'h00);
        chk("R8 fifo error set", {7'b0, status[7]}, 8'h01);
        pop();
        chk("R3 framing at head", {7'b0, status[3]}, 8'h01);
        chk("R3 head data", rx_data, 8'h22);
        rd();
        chk("R4 framing cleared", {7'b0, status[3]}, 8'h00);
        chk("R9 fifo error kept while queued", {7'b0, status[7]}, 8'h01);
        pop();
        chk("R10 pop keeps fifo error", {7'b0, status[7]}, 8'h01);
        rd();
        chk("R9 fifo error cleared", {7'b0, status[7]}, 8'h00);
    endtask

    task automatic t_coincide();
        push(8'h33, 3'b100);
        chk("R3 break at head", status[4:2], 3'b100);
        push(8'h44, 3'b001);
        rx_pop = 1'b1; status_rd = 1'b1; cyc();
        chk("R4 parity set with read kept", status[4:2], 3'b001);
        chk("R9 fifo error after read, one left", {7'b0, status[7]}, 8'h01);
        rd();
        chk("R4 parity cleared", status[4:2], 3'b000);
        pop(); rd();
        chk("R9 fifo error cleared after drain", {7'b0, status[7]}, 8'h00);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 16; i++) push(8'(8'h50 + i), 3'b000);
        chk("R5 no overrun when exactly full", {7'b0, status[1]}, 8'h00);
        push(8'hEE, 3'b000);
        chk("R5 overrun set", {7'b0, status[1]}, 8'h01);
        chk("R5 head unchanged", rx_data, 8'h50);
        for (int i = 0; i < 15; i++) pop();
        chk("R5 last kept", rx_data, 8'h5F);
        pop();
        chk("R5 extra dropped", {7'b0, status[0]}, 8'h00);
        rd();
        chk("R4 overrun cleared", {7'b0, status[1]}, 8'h00);
    endtask

    task automatic t_tx();
        thr_write = 1'b1; cyc();
        chk("R6 thre clears on write", {7'b0, status[5]}, 8'h00);
        chk("R7 temt clears on write", {7'b0, status[6]}, 8'h00);
        thr_empty = 1'b0; cyc();
        chk("R6 thre stays low", {7'b0, status[5]}, 8'h00);
        thr_empty = 1'b1; tsr_empty = 1'b0; cyc();
        chk("R6 thre set", {7'b0, status[5]}, 8'h01);
        chk("R7 temt low while shifting", {7'b0, status[6]}, 8'h00);
        tsr_empty = 1'b1; cyc();
        chk("R7 temt set", {7'b0, status[6]}, 8'h01);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_head_err();
        t_coincide();
        t_overrun();
        t_tx();
        finish_run();
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
            finish_run();
        end
    end
endmodule